// File: doc/BRIEF.md
# Pipelined Pre-Add Multiply-Accumulate Slice

This block is a configurable arithmetic slice. Two 18-bit operands, D and B, can first be combined by a pre-adder that adds or subtracts them. The result is multiplied by a signed A operand. A post-adder then combines the product with a second operand taken from an operand mux (Z). The mux offers three sources: zero, the external C input, or the slice's own registered result. The registered result lets the slice run as an accumulator. Switching the mux from feedback back to C starts a new accumulation.

Every pipeline register is optional. One parameter per stage, set to 0 or 1, either builds a register or turns the stage into a plain wire. Each register has a clock enable and a synchronous reset to zero. Both A stages share one enable/reset pair, and both B stages share another. A six-bit mode word drives the pre-adder and the post-adder. It is not registered, so it acts at the point where each of them sits in the pipe.

Top module: `premac_slice`

## Requirements
- R1: Each register stage is built when its parameter is 1 and is a wire when it is 0. The latency in clock edges from an input to `p_out` equals the number of built stages on that input's path. A passes A0, A1, M and P. B passes B1, B0, M and P. D passes D, B0, M and P. C passes C and P.
- R2: With `op_mode[4]`=0 the multiplier's B operand is the B1 output. With `op_mode[4]`=1 it is D+B (`op_mode[5]`=0) or D−B (`op_mode[5]`=1), wrapped to 18 bits.
- R3: The multiplier is signed 18×18 with a 36-bit product. The product is sign-extended to 48 bits before the post-adder.
- R4: The post-adder's X term is the product when `op_mode[0]`=1 and zero otherwise. The result is Z+X when `op_mode[1]`=0 and Z−X when `op_mode[1]`=1, modulo 2^48.
- R5: `op_mode[3:2]` selects Z: 00 gives zero, 01 gives the P register, 10 gives the C stage output, and 11 gives zero.
- R6: With PREG=1 and Z=01, every enabled edge adds the product to P. Selecting Z=10 restarts the sum from C on the next edge. With PREG=0 the feedback term is zero.
- R7: Every register resets synchronously to zero. Reset takes priority over a low clock enable.
- R8: A register whose clock enable is low holds its value.
- R9: The two A stages share `ce_a` and `rst_a`, and the two B stages share `ce_b` and `rst_b`. One reset edge clears both stages of a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| ce_a | input | 1 | Clock enable, both A stages |
| rst_a | input | 1 | Synchronous reset, both A stages |
| ce_b | input | 1 | Clock enable, both B stages |
| rst_b | input | 1 | Synchronous reset, both B stages |
| ce_d | input | 1 | Clock enable, D stage |
| rst_d | input | 1 | Synchronous reset, D stage |
| ce_c | input | 1 | Clock enable, C stage |
| rst_c | input | 1 | Synchronous reset, C stage |
| ce_m | input | 1 | Clock enable, product stage |
| rst_m | input | 1 | Synchronous reset, product stage |
| ce_p | input | 1 | Clock enable, result stage |
| rst_p | input | 1 | Synchronous reset, result stage |
| op_mode | input | 6 | [0] X on, [1] post subtract, [3:2] Z select, [4] pre-adder on, [5] pre subtract |
| a_in | input | AW | Signed multiplier operand A |
| b_in | input | BW | Operand B |
| d_in | input | BW | Pre-adder operand D |
| c_in | input | PW | Post-adder operand C |
| p_out | output | PW | Result |

## Verification
The bench streams random operands with extreme values mixed in, under several mode words. These include the most negative product and pre-adder wrap-around. A missing sign extension or a wrong subtraction order shows up as a wrong upper result word. A directed run counts the exact edge at which a D change and a C change reach the output, so a stage left out of a path or added to it is caught. The accumulator is stepped, then restarted from C, with the unregistered variant expected to show no feedback. The bench also checks that a held enable freezes the result, that reset wins over a low enable, and that a single A reset clears both A stages. A slice that reset only the last A stage would let a stale first-stage value reach the product.

// File: rtl/premac_pkg.sv
package premac_pkg;

    typedef enum logic [1:0] {
        Z_NONE     = 2'b00,
        Z_FEEDBACK = 2'b01,
        Z_CDATA    = 2'b10,
        Z_SPARE    = 2'b11
    } zsel_e;

    typedef struct packed {
        logic  pre_sub;   // bit 5
        logic  pre_en;    // bit 4
        zsel_e zsel;      // bits 3:2
        logic  post_sub;  // bit 1
        logic  x_en;      // bit 0
    } op_t;

    localparam int OPW = $bits(op_t);

endpackage

// File: rtl/premac_stage.sv
// One optional pipeline register: reset over enable over hold.
module premac_stage #(
    parameter int W  = 18,
    parameter int EN = 1
) (
    input  logic         clk,
    input  logic         ce,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (EN != 0) begin : g_reg
            logic [W-1:0] q_d, q_q;

            always_comb begin
                q_d = q_q;
                if (ce)  q_d = d;
                if (rst) q_d = '0;
            end

            always_ff @(posedge clk) begin
                q_q <= q_d;
            end

            assign q = q_q;
        end else begin : g_wire
            logic unused_ctl;
            assign unused_ctl = ^{clk, ce, rst};
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/premac_preadd.sv
module premac_preadd #(
    parameter int W = 18
) (
    input  logic         pre_en,
    input  logic         pre_sub,
    input  logic [W-1:0] b_val,
    input  logic [W-1:0] d_val,
    output logic [W-1:0] sum
);
    always_comb begin
        if (!pre_en)      sum = b_val;
        else if (pre_sub) sum = d_val - b_val;
        else              sum = d_val + b_val;
    end
endmodule

// File: rtl/premac_postadd.sv
module premac_postadd
    import premac_pkg::*;
#(
    parameter int MW = 36,
    parameter int PW = 48
) (
    input  logic                 x_en,
    input  logic                 post_sub,
    input  zsel_e                zsel,
    input  logic signed [MW-1:0] prod,
    input  logic [PW-1:0]        c_val,
    input  logic [PW-1:0]        fb_val,
    output logic [PW-1:0]        res
);
    logic [PW-1:0] x_term, z_term;

    always_comb begin
        x_term = x_en ? PW'(prod) : '0;
        unique case (zsel)
            Z_FEEDBACK: z_term = fb_val;
            Z_CDATA:    z_term = c_val;
            default:    z_term = '0;
        endcase
        res = post_sub ? (z_term - x_term) : (z_term + x_term);
    end
endmodule

// File: rtl/premac_slice.sv
module premac_slice
    import premac_pkg::*;
#(
    parameter int AW    = 18,
    parameter int BW    = 18,
    parameter int PW    = 48,
    parameter int A0REG = 1,
    parameter int A1REG = 1,
    parameter int B1REG = 1,
    parameter int B0REG = 1,
    parameter int DREG  = 1,
    parameter int CREG  = 1,
    parameter int MREG  = 1,
    parameter int PREG  = 1
) (
    input  logic              clk,
    input  logic              ce_a,
    input  logic              rst_a,
    input  logic              ce_b,
    input  logic              rst_b,
    input  logic              ce_d,
    input  logic              rst_d,
    input  logic              ce_c,
    input  logic              rst_c,
    input  logic              ce_m,
    input  logic              rst_m,
    input  logic              ce_p,
    input  logic              rst_p,
    input  logic [OPW-1:0]    op_mode,
    input  logic [AW-1:0]     a_in,
    input  logic [BW-1:0]     b_in,
    input  logic [BW-1:0]     d_in,
    input  logic [PW-1:0]     c_in,
    output logic [PW-1:0]     p_out
);
    localparam int MW = AW + BW;

    op_t                  op;
    logic [AW-1:0]        a_mid, a_mul;
    logic [BW-1:0]        b_pre, d_pre, b_sum, b_mul;
    logic [PW-1:0]        c_post, p_next, fb;
    logic signed [AW-1:0] a_s;
    logic signed [BW-1:0] b_s;
    logic signed [MW-1:0] prod, m_q;

    assign op = op_t'(op_mode);

    // A path: two stages sharing one enable/reset pair
    premac_stage #(.W(AW), .EN(A0REG)) a0_i (
        .clk(clk), .ce(ce_a), .rst(rst_a), .d(a_in), .q(a_mid));
    premac_stage #(.W(AW), .EN(A1REG)) a1_i (
        .clk(clk), .ce(ce_a), .rst(rst_a), .d(a_mid), .q(a_mul));

    // B path: stage before and after the pre-adder
    premac_stage #(.W(BW), .EN(B1REG)) b1_i (
        .clk(clk), .ce(ce_b), .rst(rst_b), .d(b_in), .q(b_pre));
    premac_stage #(.W(BW), .EN(DREG)) d_i (
        .clk(clk), .ce(ce_d), .rst(rst_d), .d(d_in), .q(d_pre));

    premac_preadd #(.W(BW)) pre_i (
        .pre_en(op.pre_en), .pre_sub(op.pre_sub),
        .b_val(b_pre), .d_val(d_pre), .sum(b_sum));

    premac_stage #(.W(BW), .EN(B0REG)) b0_i (
        .clk(clk), .ce(ce_b), .rst(rst_b), .d(b_sum), .q(b_mul));

    // Signed multiply
    assign a_s  = a_mul;
    assign b_s  = b_mul;
    assign prod = MW'(a_s) * MW'(b_s);

    premac_stage #(.W(MW), .EN(MREG)) m_i (
        .clk(clk), .ce(ce_m), .rst(rst_m), .d(prod), .q(m_q));

    premac_stage #(.W(PW), .EN(CREG)) c_i (
        .clk(clk), .ce(ce_c), .rst(rst_c), .d(c_in), .q(c_post));

    // Feedback only exists when the result register is built
    generate
        if (PREG != 0) begin : g_fb
            assign fb = p_out;
        end else begin : g_nofb
            assign fb = '0;
        end
    endgenerate

    premac_postadd #(.MW(MW), .PW(PW)) post_i (
        .x_en(op.x_en), .post_sub(op.post_sub), .zsel(op.zsel),
        .prod(m_q), .c_val(c_post), .fb_val(fb), .res(p_next));

    premac_stage #(.W(PW), .EN(PREG)) p_i (
        .clk(clk), .ce(ce_p), .rst(rst_p), .d(p_next), .q(p_out));

endmodule

// File: rtl/premac_slice_chk.sv
module premac_slice_chk #(
    parameter int PREG  = 1,
    parameter int MREG  = 1,
    parameter int A1REG = 1,
    parameter int AW    = 18,
    parameter int MW    = 36,
    parameter int PW    = 48
) (
    input logic                 clk,
    input logic                 ce_p,
    input logic                 rst_p,
    input logic                 rst_m,
    input logic                 rst_a,
    input logic                 x_en,
    input logic                 post_sub,
    input logic [1:0]           zsel,
    input logic [PW-1:0]        p_val,
    input logic signed [MW-1:0] m_val,
    input logic [AW-1:0]        a_val
);
    logic armed_q = 1'b0;
    always_ff @(posedge clk) armed_q <= 1'b1;

    assert_p_reset_R7: assert property (@(posedge clk) disable iff (!armed_q)
        (PREG != 0) && rst_p |=> p_val == '0);

    assert_p_hold_R8: assert property (@(posedge clk) disable iff (!armed_q)
        (PREG != 0) && !rst_p && !ce_p |=> $stable(p_val));

    assert_acc_step_R6: assert property (@(posedge clk) disable iff (!armed_q)
        (PREG != 0) && ce_p && !rst_p && zsel == 2'b01 && x_en && !post_sub
        |=> p_val == $past(p_val) + PW'($past(m_val)));

    assert_zero_sum_R5: assert property (@(posedge clk) disable iff (!armed_q)
        (PREG != 0) && ce_p && !rst_p && zsel == 2'b00 && !x_en
        |=> p_val == '0);

    assert_m_reset_R7: assert property (@(posedge clk) disable iff (!armed_q)
        (MREG != 0) && rst_m |=> m_val == '0);

    assert_a_reset_R9: assert property (@(posedge clk) disable iff (!armed_q)
        (A1REG != 0) && rst_a |=> a_val == '0);
endmodule

bind premac_slice premac_slice_chk #(
    .PREG(PREG), .MREG(MREG), .A1REG(A1REG),
    .AW(AW), .MW(AW + BW), .PW(PW)
) chk_i (
    .clk(clk), .ce_p(ce_p), .rst_p(rst_p), .rst_m(rst_m), .rst_a(rst_a),
    .x_en(op_mode[0]), .post_sub(op_mode[1]), .zsel(op_mode[3:2]),
    .p_val(p_out), .m_val(m_q), .a_val(a_mul)
);

// File: tb/premac_slice_tb_top.sv
`timescale 1ns/1ps
module premac_slice_tb_top;
    logic        clk = 1'b0;
    logic        ce_a = 1'b1, rst_a = 1'b1, ce_b = 1'b1, rst_b = 1'b1;
    logic        ce_d = 1'b1, rst_d = 1'b1, ce_c = 1'b1, rst_c = 1'b1;
    logic        ce_m = 1'b1, rst_m = 1'b1, ce_p = 1'b1, rst_p = 1'b1;
    logic [5:0]  op_mode = '0;
    logic [17:0] a_in = '0, b_in = '0, d_in = '0;
    logic [47:0] c_in = '0;
    logic [47:0] p_out, p_flow;

    int nchk = 0, nerr = 0, cyc = 0;
    bit done = 0;

    logic [17:0] a_h [8];
    logic [17:0] b_h [8];
    logic [17:0] d_h [8];
    logic [47:0] c_h [8];

    always #2.5 clk = ~clk;

    premac_slice dut_i (
        .clk, .ce_a, .rst_a, .ce_b, .rst_b, .ce_d, .rst_d, .ce_c, .rst_c,
        .ce_m, .rst_m, .ce_p, .rst_p, .op_mode, .a_in, .b_in, .d_in, .c_in,
        .p_out(p_out));

    premac_slice #(.A0REG(0), .A1REG(0), .B1REG(0), .B0REG(0), .DREG(0),
                   .CREG(0), .MREG(0), .PREG(0)) dut_flow_i (
        .clk, .ce_a, .rst_a, .ce_b, .rst_b, .ce_d, .rst_d, .ce_c, .rst_c,
        .ce_m, .rst_m, .ce_p, .rst_p, .op_mode, .a_in, .b_in, .d_in, .c_in,
        .p_out(p_flow));

    function automatic logic [17:0] f_pre(logic [5:0] op, logic [17:0] b, logic [17:0] d);
        if (!op[4]) return b;
        return op[5] ? d - b : d + b;
    endfunction

    function automatic logic [47:0] f_prod(logic [17:0] a, logic [17:0] b);
        logic signed [47:0] sa, sb;
        sa = 48'($signed(a));
        sb = 48'($signed(b));
        return sa * sb;
    endfunction

    function automatic logic [47:0] f_post(logic [5:0] op, logic [47:0] pr,
                                           logic [47:0] c, logic [47:0] fb);
        logic [47:0] x, z;
        x = op[0] ? pr : 48'd0;
        case (op[3:2])
            2'b01:   z = fb;
            2'b10:   z = c;
            default: z = 48'd0;
        endcase
        return op[1] ? z - x : z + x;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
        cyc++;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [5:0] ops [5];
        logic [47:0] exp;
        void'($urandom(32'd2024));
        ops[0] = 6'b001001;  // pre off, Z=C, add
        ops[1] = 6'b011001;  // pre add
        ops[2] = 6'b111011;  // pre sub, post sub
        ops[3] = 6'b010001;  // Z=0
        ops[4] = 6'b001101;  // Z=11 spare

        ticks(3);
        chk("R7 reset state", p_out, 48'd0);
        chk("R5 unregistered variant op zero", p_flow, 48'd0);
        {rst_a, rst_b, rst_d, rst_c, rst_m, rst_p} = '0;

        // Random stream, R2 R3 R4 R5 with full pipeline and wire variant (R1)
        for (int k = 0; k < 5; k++) begin
            op_mode = ops[k];
            for (int n = 0; n < 44; n++) begin
                a_in = 18'($urandom);
                b_in = 18'($urandom);
                d_in = 18'($urandom);
                c_in = {16'($urandom), 32'($urandom)};
                case ($urandom % 6)
                    0: begin a_in = 18'h20000; b_in = 18'h20000; d_in = 18'h20000; end
                    1: begin a_in = 18'h1ffff; b_in = 18'h20000; end
                    2: begin d_in = 18'h1ffff; b_in = 18'h00001; end
                    default: ;
                endcase
                tick();
                a_h[cyc & 7] = a_in; b_h[cyc & 7] = b_in;
                d_h[cyc & 7] = d_in; c_h[cyc & 7] = c_in;
                if (n >= 4) begin
                    exp = f_post(op_mode,
                                 f_prod(a_h[(cyc-3) & 7],
                                        f_pre(op_mode, b_h[(cyc-3) & 7], d_h[(cyc-3) & 7])),
                                 c_h[(cyc-1) & 7], 48'd0);
                    chk("R2 R3 R4 R5 pipelined stream", p_out, exp);
                end
                exp = f_post(op_mode, f_prod(a_in, f_pre(op_mode, b_in, d_in)), c_in, 48'd0);
                chk("R1 R2 R3 R4 zero-latency variant", p_flow, exp);
            end
        end

        // Accumulate and restart, R6
        op_mode = 6'b001001;
        a_in = 18'd3; b_in = 18'h3fffb; d_in = '0; c_in = 48'd100;
        ticks(6);
        chk("R6 start from C", p_out, 48'd85);
        op_mode = 6'b000101;
        for (int i = 1; i <= 5; i++) begin
            tick();
            chk("R6 accumulate step", p_out, 48'd85 - 48'(15 * i));
        end
        chk("R6 no feedback without P register", p_flow, 48'hffff_ffff_fff1);
        op_mode = 6'b001001;
        tick();
        chk("R6 restart from C", p_out, 48'd85);

        // Enable hold, R8
        ce_p = 1'b0; a_in = 18'd7;
        ticks(6);
        chk("R8 result held with enable low", p_out, 48'd85);
        ce_p = 1'b1; ce_a = 1'b0; a_in = 18'd100;
        ticks(6);
        chk("R9 A stages frozen by shared enable", p_out, 48'd65);

        // Shared A reset clears both stages, R9
        rst_a = 1'b1; tick(); rst_a = 1'b0;
        ce_a = 1'b1; tick(); ce_a = 1'b0;
        ticks(4);
        chk("R9 shared reset clears first A stage", p_out, 48'd100);
        ce_a = 1'b1;
        ticks(6);
        chk("R3 product after restore", p_out, 48'hffff_ffff_fe70);

        // Reset priority, R7
        ce_p = 1'b0; rst_p = 1'b1; tick();
        chk("R7 reset wins over low enable", p_out, 48'd0);
        rst_p = 1'b0; ticks(2);
        chk("R8 zero held with enable low", p_out, 48'd0);
        ce_p = 1'b1; ticks(2);
        chk("R8 resumes when enabled", p_out, 48'hffff_ffff_fe70);
        rst_m = 1'b1; ticks(2); rst_m = 1'b0;
        chk("R7 product stage reset", p_out, 48'd100);

        // Path latency, R1
        op_mode = 6'b011001;
        a_in = 18'd1; b_in = '0; d_in = '0; c_in = '0;
        ticks(6);
        chk("R1 settle", p_out, 48'd0);
        d_in = 18'd5;
        ticks(3);
        chk("R1 D path not yet through", p_out, 48'd0);
        tick();
        chk("R1 D path four edges", p_out, 48'd5);
        c_in = 48'd1000;
        tick();
        chk("R1 C path not yet through", p_out, 48'd5);
        tick();
        chk("R1 C path two edges", p_out, 48'd1005);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule